// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Mask Registers

This block collects the event sources of an SD/MMC host controller into one 16-bit status word and one 16-bit mask word. From these it drives a single interrupt request line. Four sources are one-cycle events that are held until software acknowledges them:
- data transfer done
- programming done
- command response ended
- card interrupt

Two sources are level requests from the data buffers, receive-read and transmit-write. These bits follow the buffer condition directly and cannot be stored or cleared.

Software uses a single write port with a select bit to reach either word. Writing ones to the status word acknowledges the held events. Writing the mask word replaces it. A mask bit of 1 keeps its source away from the interrupt line but does not stop the source from being recorded. The block therefore starts with every source masked.

Top module: `sdmmc_irq_regs`

## Requirements
- R1: After reset, `mask_o` is 0xFFFF, every held status bit is 0, and `irq_o` is 0.
- R2: A one-cycle high on an event input sets its status bit at the next clock edge. The bit positions are: transfer done at bit 0, programming done at bit 1, command response ended at bit 2, card interrupt at bit 7. The bit stays set until it is cleared.
- R3: A write with `wr_sel_i`=0 clears each held status bit whose data bit is 1. Data bits that are 0 leave their bits unchanged. Writing 0xFFFF clears every held bit.
- R4: When an event pulse and a write-1 clear of the same bit arrive in the same cycle, the bit is set after the edge.
- R5: Status bit 5 equals `rx_need_i` and bit 6 equals `tx_need_i` in the same cycle, with no storage. A status write does not clear either bit while its input is high.
- R6: Status bits 3, 4 and 8 to 15 always read 0, including after a status write of 0xFFFF.
- R7: A write with `wr_sel_i`=1 stores all 16 data bits into `mask_o` at the next edge, unused positions included. Without such a write, the mask holds its value.
- R8: `irq_o` is 1 exactly when some status bit is 1 while its mask bit is 0. A mask bit of 1 disables its source.
- R9: A masked event still sets its status bit, and it raises `irq_o` once its mask bit is cleared.
- R10: A status write leaves `mask_o` unchanged, and a mask write leaves the held status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write 1 to clear), 1 mask |
| wr_data_i | input | 16 | Write data |
| ev_xfer_done_i | input | 1 | Transfer done event pulse |
| ev_prog_done_i | input | 1 | Programming done event pulse |
| ev_cmd_end_i | input | 1 | Command response ended event pulse |
| ev_card_i | input | 1 | Card interrupt event pulse |
| rx_need_i | input | 1 | Receive buffer needs reading (level) |
| tx_need_i | input | 1 | Transmit buffer needs filling (level) |
| status_o | output | 16 | Status word |
| mask_o | output | 16 | Mask word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a status write clearing that same bit. Directed steps align the pulse and the clear on one edge. A long random phase then produces many more such collisions, because it mixes random status writes with random pulses on all four event inputs.

The second corner is a masked event followed later by an unmask. The random phase reaches this by interleaving random mask writes with events. A behavioural model checks every cycle, comparing status, mask and interrupt, and it tracks the level bits while clears are aimed at them.

// File: rtl/sdmmc_irq_pkg.sv
package sdmmc_irq_pkg;
  localparam int unsigned REG_W = 16;

  localparam int unsigned BIT_XFER_DONE = 0;
  localparam int unsigned BIT_PROG_DONE = 1;
  localparam int unsigned BIT_CMD_END   = 2;
  localparam int unsigned BIT_RX_NEED   = 5;
  localparam int unsigned BIT_TX_NEED   = 6;
  localparam int unsigned BIT_CARD      = 7;

  typedef logic [REG_W-1:0] irq_word_t;

  localparam irq_word_t HELD_BITS  = (irq_word_t'(1) << BIT_XFER_DONE)
                                   | (irq_word_t'(1) << BIT_PROG_DONE)
                                   | (irq_word_t'(1) << BIT_CMD_END)
                                   | (irq_word_t'(1) << BIT_CARD);
  localparam irq_word_t LEVEL_BITS = (irq_word_t'(1) << BIT_RX_NEED)
                                   | (irq_word_t'(1) << BIT_TX_NEED);
  localparam irq_word_t MASK_RESET = '1;
endpackage

// File: rtl/irq_held_bank.sv
module irq_held_bank #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_held
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b0;
        else         q_q <= set_i[i] | (q_q & ~clr_i[i]);
      end
      assign q_o[i] = q_q;

      // event beats clear
      assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      assert_clear_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
      assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RESET = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RESET;
    else if (we_i) q_q <= d_i;
  end
  assign q_o = q_q;

  assert_mask_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
  assert_mask_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] live;

  always_comb begin
    live  = status_i & ~mask_i;
    irq_o = |live;
  end
endmodule

// File: rtl/sdmmc_irq_regs.sv
module sdmmc_irq_regs
  import sdmmc_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [15:0] wr_data_i,
  input  logic        ev_xfer_done_i,
  input  logic        ev_prog_done_i,
  input  logic        ev_cmd_end_i,
  input  logic        ev_card_i,
  input  logic        rx_need_i,
  input  logic        tx_need_i,
  output logic [15:0] status_o,
  output logic [15:0] mask_o,
  output logic        irq_o
);
  irq_word_t set_vec, clr_vec, level_vec, held_q, mask_q;
  logic      wr_status, wr_mask;

  always_comb begin
    wr_status = wr_en_i && !wr_sel_i;
    wr_mask   = wr_en_i &&  wr_sel_i;

    set_vec                = '0;
    set_vec[BIT_XFER_DONE] = ev_xfer_done_i;
    set_vec[BIT_PROG_DONE] = ev_prog_done_i;
    set_vec[BIT_CMD_END]   = ev_cmd_end_i;
    set_vec[BIT_CARD]      = ev_card_i;

    clr_vec = wr_status ? (wr_data_i & HELD_BITS) : '0;

    level_vec              = '0;
    level_vec[BIT_RX_NEED] = rx_need_i;
    level_vec[BIT_TX_NEED] = tx_need_i;
  end

  irq_held_bank #(.W(REG_W), .KEEP(HELD_BITS)) u_held (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (held_q)
  );

  irq_mask_reg #(.W(REG_W), .RESET(MASK_RESET)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_mask),
    .d_i    (wr_data_i),
    .q_o    (mask_q)
  );

  assign status_o = held_q | level_vec;
  assign mask_o   = mask_q;

  irq_combine #(.W(REG_W)) u_comb (
    .status_i (status_o),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  assert_card_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_card_i |=> status_o[BIT_CARD]);
  assert_masked_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_xfer_done_i && mask_o[BIT_XFER_DONE]) |=> status_o[BIT_XFER_DONE]);
  assert_all_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '1) |-> !irq_o);
  assert_level_survives_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && rx_need_i) |-> status_o[BIT_RX_NEED]);
  assert_status_wr_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> $stable(mask_o));
endmodule

// File: tb/sdmmc_irq_regs_test.sv
`timescale 1ns/1ps
module sdmmc_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ev_x = 1'b0, ev_p = 1'b0, ev_c = 1'b0, ev_k = 1'b0;
  logic        rx = 1'b0, tx = 1'b0;
  logic [15:0] status, mask;
  logic        irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference state
  int m_held = 0;
  int m_mask = 'hFFFF;

  always #2.5 clk = ~clk;

  sdmmc_irq_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ev_xfer_done_i(ev_x), .ev_prog_done_i(ev_p),
    .ev_cmd_end_i(ev_c), .ev_card_i(ev_k), .rx_need_i(rx), .tx_need_i(tx),
    .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_status();
    return m_held | (int'(rx) << 5) | (int'(tx) << 6);
  endfunction

  task automatic compare_model();
    chk("R2 R5 R6 status vs model", int'(status), exp_status());
    chk("R7 R10 mask vs model", int'(mask), m_mask);
    chk("R8 irq vs model", int'(irq), int'((exp_status() & ~m_mask & 'hFFFF) != 0));
  endtask

  task automatic step(input bit we, input bit sel, input int d,
                      input bit x, input bit p, input bit c, input bit k,
                      input bit r, input bit t);
    int setv, clrv;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d[15:0];
    ev_x = x; ev_p = p; ev_c = c; ev_k = k; rx = r; tx = t;
    #1 compare_model();
    @(posedge clk);
    setv = (int'(x) << 0) | (int'(p) << 1) | (int'(c) << 2) | (int'(k) << 7);
    clrv = (we && !sel) ? d : 0;
    m_held = (m_held & ~clrv) | setv;
    m_held = m_held & 'h87;
    if (we && sel) m_mask = d & 'hFFFF;
    #1;
  endtask

  task automatic idle(input bit r = 0, input bit t = 0);
    step(0, 0, 0, 0, 0, 0, 0, r, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 mask reset", int'(mask), 'hFFFF);
    chk("R1 status reset", int'(status), 0);
    chk("R1 irq reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;

    // R9 masked event still latches, no irq
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R9 masked xfer latched", int'(status), 'h0001);
    chk("R9 masked irq low", int'(irq), 0);
    // R8 unmask bit 0 raises irq
    step(1, 1, 'hFFFE, 0, 0, 0, 0, 0, 0);
    chk("R8 unmasked irq high", int'(irq), 1);
    chk("R7 mask readback", int'(mask), 'hFFFE);
    // R3 write 0 leaves bit
    step(1, 0, 'h0000, 0, 0, 0, 0, 0, 0);
    chk("R3 write zero keeps", int'(status), 'h0001);
    step(1, 0, 'h0001, 0, 0, 0, 0, 0, 0);
    chk("R3 write one clears", int'(status), 'h0000);
    chk("R8 irq drops after clear", int'(irq), 0);
    // R2 positions of each held event
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R2 prog done bit1", int'(status), 'h0002);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 cmd end bit2", int'(status), 'h0006);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R2 card bit7", int'(status), 'h0086);
    idle();
    chk("R2 held without input", int'(status), 'h0086);
    // R4 clear and pulse same cycle
    step(1, 0, 'h0080, 0, 0, 0, 1, 0, 0);
    chk("R4 event beats clear", int'(status), 'h0086);
    // R3 clear everything
    step(1, 0, 'hFFFF, 0, 0, 0, 0, 0, 0);
    chk("R3 all cleared", int'(status), 'h0000);
    // R5 level bits follow, not cleared by write
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 rx level", int'(status), 'h0020);
    step(1, 0, 'hFFFF, 0, 0, 0, 0, 1, 1);
    chk("R5 levels survive clear", int'(status), 'h0060);
    idle();
    chk("R5 levels drop with input", int'(status), 'h0000);
    // R6 unused bits
    step(1, 0, 'hFF18, 0, 0, 0, 0, 0, 0);
    chk("R6 unused read zero", int'(status), 'h0000);
    // R7 / R10 mask stores all bits, status unaffected
    step(0, 0, 0, 1, 0, 0, 1, 0, 0);
    step(1, 1, 'hA5C3, 0, 0, 0, 0, 0, 0);
    chk("R7 unused mask bits stored", int'(mask), 'hA5C3);
    chk("R10 mask write keeps status", int'(status), 'h0081);
    step(1, 0, 'h0001, 0, 0, 0, 0, 0, 0);
    chk("R10 status write keeps mask", int'(mask), 'hA5C3);
    chk("R8 masked card quiet", int'(irq), 0);
    step(1, 1, 'h0000, 0, 0, 0, 0, 0, 0);
    chk("R9 unmask raises irq", int'(irq), 1);

    // random phase with model comparison each cycle
    for (int i = 0; i < 3000; i++) begin
      int rnd;
      rnd = $urandom;
      step((rnd & 7) == 0, rnd[3], $urandom & 'hFFFF,
           (rnd >> 4 & 7) == 0, (rnd >> 7 & 7) == 0,
           (rnd >> 10 & 7) == 0, (rnd >> 13 & 7) == 0,
           rnd[16] & rnd[17], rnd[18] & rnd[19]);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule